// File: doc/BRIEF.md
# Multifunction 32-bit ALU

This block is the combinational execution unit of a single-cycle integer datapath. It takes two 32-bit operands and a 4-bit operation code. The code's upper two bits pick one of four sub-units: shift, set-less-than, arithmetic or logic. Its lower two bits pick the operation inside that sub-unit. From these it forms a 32-bit result, a zero flag and a signed-overflow flag.

A single adder with a carry-in serves both add and subtract. To subtract, the adder inverts the second operand and forces the carry-in high. The signed compare reuses the same subtraction and does not have a comparator of its own: it corrects the difference's sign bit with the overflow condition. The shifter sits outside this block. Its 32-bit result comes in on a port and passes through when the shift unit is selected. The block has no clock and no state, so every output is a function of the current inputs.

Top module: `alu32_core`

## Requirements
- R1: With unit select `op_code[3:2]` = 00 (shift), `result` equals `shift_res` whatever the sub-operation bits are.
- R2: With unit select 10 (arithmetic) and `op_code[0]` = 0, `result` is `opnd_a + opnd_b` modulo 2^32.
- R3: With unit select 10 and `op_code[0]` = 1, `result` is `opnd_a - opnd_b` modulo 2^32.
- R4: In the arithmetic unit, `op_code[1]` has no effect on `result` or `ovf_flag`.
- R5: With unit select 11 (logic), `op_code[1:0]` picks the operation: 00 bitwise AND, 01 OR, 10 NOR, 11 XOR.
- R6: With unit select 01 (set-less-than), `result` is 1 when `opnd_a` is less than `opnd_b` as a two's-complement signed value, and 0 otherwise. The answer is zero-extended to 32 bits, it is correct even when the internal subtraction overflows, and `op_code[1:0]` is ignored.
- R7: `zero_flag` is 1 exactly when all 32 bits of `result` are 0.
- R8: `ovf_flag` is 1 only in the arithmetic unit, and only when the signed add or subtract overflows: the two adder inputs (after any inversion of `opnd_b`) share a sign that differs from the sign of the sum. In the other three units it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| shift_res | input | 32 | Externally computed shift result |
| op_code | input | 4 | [3:2] unit select, [1:0] sub-operation |
| result | output | 32 | Selected result |
| zero_flag | output | 1 | Result is all zeros |
| ovf_flag | output | 1 | Signed overflow of an arithmetic operation |

## Verification
The bench builds the block with its default width of 32. At that width the signed boundary values are within reach: 0x7FFFFFFF plus 1, 0x80000000 minus 1, and compares across the sign boundary where the internal difference overflows. Each of these corrections is checked against a behavioural model that compares signed values directly rather than reading a sign bit. Random operands are also driven with every one of the sixteen operation codes, so the sub-operation bits that each unit ignores are exercised as well.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

    typedef enum logic [1:0] {
        UNIT_SHIFT = 2'b00,
        UNIT_SLT   = 2'b01,
        UNIT_ARITH = 2'b10,
        UNIT_LOGIC = 2'b11
    } unit_sel_e;

    typedef enum logic [1:0] {
        LOG_AND = 2'b00,
        LOG_OR  = 2'b01,
        LOG_NOR = 2'b10,
        LOG_XOR = 2'b11
    } logic_op_e;

endpackage

// File: rtl/alu32_addsub.sv
module alu32_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic         subtract,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = in_b ^ {W{subtract}};
        sum   = in_a + b_eff + W'(subtract);
        ovf   = (in_a[W-1] == b_eff[W-1]) && (sum[W-1] != in_a[W-1]);
    end
endmodule

// File: rtl/alu32_logic.sv
module alu32_logic
    import alu32_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic_op_e    sel,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            LOG_AND: y = in_a & in_b;
            LOG_OR:  y = in_a | in_b;
            LOG_NOR: y = ~(in_a | in_b);
            LOG_XOR: y = in_a ^ in_b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu32_outsel.sv
module alu32_outsel
    import alu32_pkg::*;
#(
    parameter int W = 32
) (
    input  unit_sel_e    unit,
    input  logic [W-1:0] from_shift,
    input  logic [W-1:0] from_slt,
    input  logic [W-1:0] from_arith,
    input  logic [W-1:0] from_logic,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (unit)
            UNIT_SHIFT: y = from_shift;
            UNIT_SLT:   y = from_slt;
            UNIT_ARITH: y = from_arith;
            UNIT_LOGIC: y = from_logic;
            default:    y = '0;
        endcase
    end
endmodule

// File: rtl/alu32_core.sv
module alu32_core
    import alu32_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] shift_res,
    input  logic [3:0]   op_code,
    output logic [W-1:0] result,
    output logic         zero_flag,
    output logic         ovf_flag
);
    unit_sel_e    unit;
    logic         do_sub;
    logic [W-1:0] add_sum;
    logic         add_ovf;
    logic [W-1:0] slt_word;
    logic [W-1:0] logic_y;

    always_comb begin
        unit   = unit_sel_e'(op_code[3:2]);
        do_sub = (unit == UNIT_SLT) || ((unit == UNIT_ARITH) && op_code[0]);
    end

    alu32_addsub #(.W(W)) i_addsub (
        .in_a     (opnd_a),
        .in_b     (opnd_b),
        .subtract (do_sub),
        .sum      (add_sum),
        .ovf      (add_ovf)
    );

    alu32_logic #(.W(W)) i_logic (
        .in_a (opnd_a),
        .in_b (opnd_b),
        .sel  (logic_op_e'(op_code[1:0])),
        .y    (logic_y)
    );

    // signed less-than: sign of the difference corrected by overflow
    always_comb begin
        slt_word    = '0;
        slt_word[0] = add_sum[W-1] ^ add_ovf;
    end

    alu32_outsel #(.W(W)) i_outsel (
        .unit       (unit),
        .from_shift (shift_res),
        .from_slt   (slt_word),
        .from_arith (add_sum),
        .from_logic (logic_y),
        .y          (result)
    );

    always_comb begin
        zero_flag = ~|result;
        ovf_flag  = (unit == UNIT_ARITH) && add_ovf;
    end
endmodule

// File: rtl/alu32_core_chk.sv
module alu32_core_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] shift_res,
    input logic [3:0]   op_code,
    input logic [W-1:0] result,
    input logic         zero_flag,
    input logic         ovf_flag
);
    always_comb begin
        if (op_code[3:2] == 2'b00) begin
            assert_shift_pass_R1: assert (result == shift_res);
        end
        if (op_code[3:2] == 2'b10 && op_code[0]) begin
            assert_sub_value_R3: assert (result == opnd_a - opnd_b);
        end
        if (op_code == 4'b1110) begin
            assert_nor_value_R5: assert (result == ~(opnd_a | opnd_b));
        end
        if (op_code[3:2] == 2'b01) begin
            assert_slt_range_R6: assert (result[W-1:1] == '0);
        end
        if (op_code == 4'b1111) begin
            assert_xor_zero_R7: assert (zero_flag == (opnd_a == opnd_b));
        end
        if (op_code[3:2] != 2'b10) begin
            assert_no_overflow_R8: assert (!ovf_flag);
        end
    end
endmodule

bind alu32_core alu32_core_chk #(.W(W)) i_chk (.*);

// File: tb/test_alu32_core.sv
module test_alu32_core;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        z;
        logic        v;
        logic [3:0]  req;
    } vec_t;

    localparam logic [31:0] SH = 32'hA5A5_0F0F;
    localparam int NV = 17;

    localparam vec_t TAB [NV] = '{
        '{4'b1000, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1, 4'd2}, // R2 R8
        '{4'b1001, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 1'b1, 4'd3}, // R3 R8
        '{4'b1001, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000, 1'b1, 1'b0, 4'd7}, // R7
        '{4'b1000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0, 4'd8}, // carry, no overflow
        '{4'b1010, 32'h0000_0005, 32'h0000_0003, 32'h0000_0008, 1'b0, 1'b0, 4'd4}, // R4
        '{4'b1011, 32'h0000_0005, 32'h0000_0003, 32'h0000_0002, 1'b0, 1'b0, 4'd4},
        '{4'b1100, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000, 1'b0, 1'b0, 4'd5}, // R5
        '{4'b1101, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hFFF0_FFF0, 1'b0, 1'b0, 4'd5},
        '{4'b1110, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h000F_000F, 1'b0, 1'b0, 4'd5},
        '{4'b1111, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FF0_0FF0, 1'b0, 1'b0, 4'd5},
        '{4'b0100, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 4'd6}, // R6
        '{4'b0100, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b0, 4'd6},
        '{4'b0100, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 4'd6},
        '{4'b0100, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b1, 1'b0, 4'd6},
        '{4'b0111, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 4'd6},
        '{4'b0011, 32'h7FFF_FFFF, 32'h0000_0001, SH,            1'b0, 1'b0, 4'd1}, // R1
        '{4'b1111, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h0000_0000, 1'b1, 1'b0, 4'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] shift_res = '0;
    logic [3:0]  op_code = '0;
    logic [31:0] result;
    logic        zero_flag;
    logic        ovf_flag;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    alu32_core i_alu32_core (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .shift_res (shift_res),
        .op_code   (op_code),
        .result    (result),
        .zero_flag (zero_flag),
        .ovf_flag  (ovf_flag)
    );

    function automatic logic [33:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [31:0] sh);
        logic [31:0] r;
        logic        v;
        v = 1'b0;
        case (op[3:2])
            2'b00: r = sh;
            2'b01: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            2'b10: begin
                if (op[0]) begin
                    r = a - b;
                    v = (a[31] != b[31]) && (r[31] != a[31]);
                end else begin
                    r = a + b;
                    v = (a[31] == b[31]) && (r[31] != a[31]);
                end
            end
            default: case (op[1:0])
                2'b00: r = a & b;
                2'b01: r = a | b;
                2'b10: r = ~(a | b);
                default: r = a ^ b;
            endcase
        endcase
        return {r, (r == 32'd0), v};
    endfunction

    task automatic check(input logic [31:0] er, input logic ez, input logic ev, input string tag);
        checks++;
        if (result !== er || zero_flag !== ez || ovf_flag !== ev) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h: got res=%h z=%b v=%b expected res=%h z=%b v=%b",
                     tag, op_code, opnd_a, opnd_b, result, zero_flag, ovf_flag, er, ez, ev);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] sh);
        @(posedge clk);
        op_code = op; opnd_a = a; opnd_b = b; shift_res = sh;
        @(negedge clk);
    endtask

    initial begin
        logic [33:0] m;
        // reset state: all inputs zero selects shift unit with a zero shift value
        repeat (3) @(negedge clk);
        check(32'd0, 1'b1, 1'b0, "R1 R7 reset");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(TAB[i].op, TAB[i].a, TAB[i].b, SH);
            check(TAB[i].res, TAB[i].z, TAB[i].v, $sformatf("R%0d table %0d", TAB[i].req, i));
        end

        // directed: shift zero value raises zero flag (R1, R7)
        drive(4'b0001, 32'h1234_5678, 32'h1, 32'h0);
        check(32'h0, 1'b1, 1'b0, "R1 shift zero");
        // directed: R4 bit1 ignored with overflow present
        drive(4'b1010, 32'h7FFF_FFFF, 32'h1, SH);
        check(32'h8000_0000, 1'b0, 1'b1, "R4 add overflow");
        // directed: R8 SLT internal overflow not reported
        drive(4'b0110, 32'h8000_0000, 32'h1, SH);
        check(32'h1, 1'b0, 1'b0, "R8 slt no ovf");

        // random sweep against the model, all sixteen codes
        for (int i = 0; i < 400; i++) begin
            logic [3:0]  op;
            logic [31:0] a, b, sh;
            op = 4'(i % 16);
            a = $urandom; b = $urandom; sh = $urandom;
            if (i % 7 == 0) b = a;
            m = model(op, a, b, sh);
            drive(op, a, b, sh);
            check(m[33:2], m[1], m[0], "R2 R3 R5 R6 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule